// File: doc/BRIEF.md
# Cancellable Validate Delay Queue

This block sits between the logic that detects a cache line returning to an earlier value and the coherence bus that tells other processors their stale copies are good again. A validate for a line is not issued at once. It waits in a small in-order queue for a fixed number of cycles. If the local processor writes a new value to the same line during that wait, the validate has become useless. The waiting request is then cancelled and never reaches the bus. Only validates that reach their age with no such write are offered on a valid/ready output.

Each accepted validate records the value of a free-running cycle stamp. Its age is the current stamp minus the recorded one. Every store notification is compared against all waiting entries in the same cycle. Cancelled entries stay in their slot until they reach the head, where they are discarded in one cycle with no output. An enqueue that arrives while the queue is full is lost and counted.

Top module: `validate_delay_queue`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `outValid` is 0, `dropCount` is 0 and the queue holds no entries.
- R2: A validate enqueued at clock edge k (with `enqValid` high) is not offered before edge k+DELAY-1. It is offered (`outValid`=1, `outLine` = its line) in the cycle after edge k+DELAY-1, provided it is at the head and has not been cancelled. Counted this way, DELAY edges including the enqueue edge must pass.
- R3: Validates leave in the order they were accepted. Exactly one entry leaves per edge where `outValid` and `outReady` are both high.
- R4: A clock edge with `storeValid` high and `storeLine` equal to a waiting entry's line cancels that entry, and it is never offered. In any cycle where `storeValid` is high and `storeLine` equals the head's line, `outValid` is 0.
- R5: One store notification cancels every waiting entry with a matching line in the same edge. Entries with other lines are unaffected.
- R6: If `enqValid` and `storeValid` are high at the same edge with equal lines, the newly accepted entry survives and older entries for that line are cancelled.
- R7: While `outReady` is low, an offered entry keeps `outValid` high and `outLine` unchanged. It can still be cancelled by a matching store until it is accepted.
- R8: The queue holds DEPTH entries, and cancelled entries not yet discarded count as held. An enqueue at an edge where DEPTH entries are held is discarded, and `dropCount` increases by exactly 1. `dropCount` changes at no other edge.
- R9: A cancelled entry at the head is removed at the next edge without raising `outValid`. The following entry then becomes the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enqValid | input | 1 | A validate for `enqLine` is to be queued |
| enqLine | input | LINE_W | Line address of the validate |
| storeValid | input | 1 | A value-changing store occurred |
| storeLine | input | LINE_W | Line address written by that store |
| outValid | output | 1 | An aged, uncancelled validate is offered |
| outLine | output | LINE_W | Line address of the offered validate |
| outReady | input | 1 | Bus accepts the offered validate |
| dropCount | output | DROP_W | Number of validates discarded because the queue was full |

## Verification
The hardest situation to reach is a cancellation that races with release. This includes a store arriving in the last waiting cycle, in the very cycle the entry is first offered, or while the offer is stalled. Reaching these needs stimulus timed to the exact edge. The vector table places a store at a chosen offset from the enqueue edge, including offset zero (same edge as the enqueue) and offsets at and just before the release point. Directed sequences then hold `outReady` low to park an offered entry, cancel it, and fill the queue past DEPTH before draining it.

// File: rtl/vdq_pkg.sv
package vdq_pkg;

  // Strobes from the control to the entry storage
  typedef struct packed {
    logic push;   // write the slot at the write pointer
    logic pop;    // free the slot at the read pointer
  } vdqStrobe_t;

endpackage

// File: rtl/vdq_datapath.sv
module vdq_datapath #(
  parameter int LINE_W = 32,
  parameter int DEPTH  = 8,
  parameter int DELAY  = 27,
  parameter int PTR_W  = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  vdq_pkg::vdqStrobe_t    strobe,
  input  logic [PTR_W-1:0]       wrPtr,
  input  logic [PTR_W-1:0]       rdPtr,
  input  logic [LINE_W-1:0]      enqLine,
  input  logic                   storeValid,
  input  logic [LINE_W-1:0]      storeLine,
  output logic                   headOcc,
  output logic                   headLive,
  output logic                   headRipe,
  output logic                   headHit,
  output logic [LINE_W-1:0]      headLine
);

  // Stamp wide enough that an age reaches DELAY before wrapping
  localparam int STAMP_W = $clog2(DELAY + 1) + 1;
  localparam logic [STAMP_W-1:0] DELAY_T = STAMP_W'(DELAY);

  logic [STAMP_W-1:0] nowStamp;

  logic [DEPTH-1:0]  occV;
  logic [DEPTH-1:0]  liveV;
  logic [DEPTH-1:0]  ripeV;
  logic [DEPTH-1:0]  ageMetV;
  logic [DEPTH-1:0]  matchV;
  logic [LINE_W-1:0] lineArr [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nowStamp <= '0;
    else       nowStamp <= nowStamp + STAMP_W'(1);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    logic               occR;
    logic               liveR;
    logic               ripeR;
    logic [LINE_W-1:0]  lineR;
    logic [STAMP_W-1:0] stampR;
    logic [STAMP_W-1:0] age;
    logic               isWr;
    logic               isRd;

    assign isWr = strobe.push && (wrPtr == PTR_W'(i));
    assign isRd = strobe.pop  && (rdPtr == PTR_W'(i));
    assign age  = nowStamp - stampR;

    assign ageMetV[i] = occR && (age >= DELAY_T);
    assign matchV[i]  = occR && storeValid && (lineR == storeLine);
    assign occV[i]    = occR;
    assign liveV[i]   = liveR;
    assign ripeV[i]   = ripeR;
    assign lineArr[i] = lineR;

    // Slot state: a fresh write wins over a cancellation in the same edge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        occR  <= 1'b0;
        liveR <= 1'b0;
        ripeR <= 1'b0;
      end else if (isWr) begin
        occR  <= 1'b1;
        liveR <= 1'b1;
        ripeR <= 1'b0;
      end else begin
        if (isRd)       occR  <= 1'b0;
        if (matchV[i])  liveR <= 1'b0;
        if (ageMetV[i]) ripeR <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (isWr) begin
        lineR  <= enqLine;
        stampR <= nowStamp;
      end
    end
  end

  // Head view for the control
  assign headOcc  = occV[rdPtr];
  assign headLive = liveV[rdPtr];
  assign headRipe = ripeV[rdPtr] | ageMetV[rdPtr];
  assign headHit  = matchV[rdPtr];
  assign headLine = lineArr[rdPtr];

endmodule

// File: rtl/vdq_ctrl.sv
module vdq_ctrl #(
  parameter int DEPTH  = 8,
  parameter int PTR_W  = 3,
  parameter int CNT_W  = 4,
  parameter int DROP_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enqValid,
  input  logic                 outReady,
  input  logic                 headOcc,
  input  logic                 headLive,
  input  logic                 headRipe,
  input  logic                 headHit,
  output logic                 outValid,
  output vdq_pkg::vdqStrobe_t  strobe,
  output logic [PTR_W-1:0]     wrPtr,
  output logic [PTR_W-1:0]     rdPtr,
  output logic [CNT_W-1:0]     occCount,
  output logic [DROP_W-1:0]    dropCount
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic full;
  logic dropNow;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  assign full     = (occCount == FULL_CNT);
  assign dropNow  = enqValid && full;
  // A head hit by a store this cycle is withheld; it dies at the edge
  assign outValid = headOcc && headLive && headRipe && !headHit;

  always_comb begin
    strobe      = '0;
    strobe.push = enqValid && !full;
    strobe.pop  = headOcc && (!headLive || (outValid && outReady));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      occCount  <= '0;
      dropCount <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strobe.push, strobe.pop})
        2'b10:   occCount <= occCount + CNT_W'(1);
        2'b01:   occCount <= occCount - CNT_W'(1);
        default: occCount <= occCount;
      endcase
      if (dropNow) dropCount <= dropCount + DROP_W'(1);
    end
  end

endmodule

// File: rtl/validate_delay_queue.sv
module validate_delay_queue #(
  parameter int LINE_W = 32,
  parameter int DEPTH  = 8,
  parameter int DELAY  = 27,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enqValid,
  input  logic [LINE_W-1:0] enqLine,
  input  logic              storeValid,
  input  logic [LINE_W-1:0] storeLine,
  output logic              outValid,
  output logic [LINE_W-1:0] outLine,
  input  logic              outReady,
  output logic [DROP_W-1:0] dropCount
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  vdq_pkg::vdqStrobe_t strobe;
  logic [PTR_W-1:0]    wrPtr;
  logic [PTR_W-1:0]    rdPtr;
  logic [CNT_W-1:0]    occCount;
  logic                headOcc;
  logic                headLive;
  logic                headRipe;
  logic                headHit;

  vdq_ctrl #(
    .DEPTH (DEPTH),
    .PTR_W (PTR_W),
    .CNT_W (CNT_W),
    .DROP_W(DROP_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .enqValid (enqValid),
    .outReady (outReady),
    .headOcc  (headOcc),
    .headLive (headLive),
    .headRipe (headRipe),
    .headHit  (headHit),
    .outValid (outValid),
    .strobe   (strobe),
    .wrPtr    (wrPtr),
    .rdPtr    (rdPtr),
    .occCount (occCount),
    .dropCount(dropCount)
  );

  vdq_datapath #(
    .LINE_W(LINE_W),
    .DEPTH (DEPTH),
    .DELAY (DELAY),
    .PTR_W (PTR_W)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrPtr     (wrPtr),
    .rdPtr     (rdPtr),
    .enqLine   (enqLine),
    .storeValid(storeValid),
    .storeLine (storeLine),
    .headOcc   (headOcc),
    .headLive  (headLive),
    .headRipe  (headRipe),
    .headHit   (headHit),
    .headLine  (outLine)
  );

endmodule

// File: rtl/vdq_checker.sv
module vdq_checker #(
  parameter int LINE_W = 32,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4,
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              enqValid,
  input logic              storeValid,
  input logic [LINE_W-1:0] storeLine,
  input logic              outValid,
  input logic [LINE_W-1:0] outLine,
  input logic              outReady,
  input logic [DROP_W-1:0] dropCount,
  input logic [CNT_W-1:0]  occCount
);

  // R7: a stalled offer keeps its line or is withdrawn by a cancel
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> !outValid || (outLine == $past(outLine)));

  // R4: a line being written is never offered in that cycle
  a_r4_no_offer_on_hit: assert property (@(posedge clk) disable iff (!rstN)
    outValid && storeValid |-> outLine != storeLine);

  // R8: enqueue into a full queue bumps the drop count by one
  a_r8_drop_on_full: assert property (@(posedge clk) disable iff (!rstN)
    enqValid && (occCount == CNT_W'(DEPTH)) |=> dropCount == $past(dropCount) + DROP_W'(1));

  // R8: otherwise the drop count holds
  a_r8_drop_hold: assert property (@(posedge clk) disable iff (!rstN)
    !enqValid || (occCount != CNT_W'(DEPTH)) |=> $stable(dropCount));

  // R8: occupancy never exceeds the depth
  a_r8_occ_bound: assert property (@(posedge clk) disable iff (!rstN)
    occCount <= CNT_W'(DEPTH));

  // R3: an empty queue offers nothing
  a_r3_empty_quiet: assert property (@(posedge clk) disable iff (!rstN)
    occCount == '0 |-> !outValid);

endmodule

bind validate_delay_queue vdq_checker #(
  .LINE_W(LINE_W),
  .DEPTH (DEPTH),
  .CNT_W (CNT_W),
  .DROP_W(DROP_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .enqValid  (enqValid),
  .storeValid(storeValid),
  .storeLine (storeLine),
  .outValid  (outValid),
  .outLine   (outLine),
  .outReady  (outReady),
  .dropCount (dropCount),
  .occCount  (occCount)
);

// File: tb/validate_delay_queue_test.sv
`timescale 1ns/100ps
module validate_delay_queue_test;

  localparam int LINE_W = 32;
  localparam int DEPTH  = 8;
  localparam int DELAY  = 27;
  localparam int DROP_W = 16;
  localparam int NV     = 6;

  // {enqLine[73:42], hasStore[41], storeLine[40:9], storeOffset[8:1], expectOut[0]}
  localparam logic [73:0] VEC [NV] = '{
    {32'h0000_0100, 1'b0, 32'h0000_0000, 8'd0,  1'b1},
    {32'h0000_0140, 1'b1, 32'h0000_0140, 8'd5,  1'b0},
    {32'h0000_0180, 1'b1, 32'h0000_01C0, 8'd5,  1'b1},
    {32'h0000_0200, 1'b1, 32'h0000_0200, 8'd0,  1'b1},
    {32'h0000_0240, 1'b1, 32'h0000_0240, 8'd26, 1'b0},
    {32'h0000_0280, 1'b1, 32'h0000_0280, 8'd27, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rstN;
  logic              enqValid;
  logic [LINE_W-1:0] enqLine;
  logic              storeValid;
  logic [LINE_W-1:0] storeLine;
  logic              outValid;
  logic [LINE_W-1:0] outLine;
  logic              outReady;
  logic [DROP_W-1:0] dropCount;

  int  checks   = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  validate_delay_queue #(
    .LINE_W(LINE_W), .DEPTH(DEPTH), .DELAY(DELAY), .DROP_W(DROP_W)
  ) uut (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqLine(enqLine),
    .storeValid(storeValid), .storeLine(storeLine), .outValid(outValid),
    .outLine(outLine), .outReady(outReady), .dropCount(dropCount)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] line);
    enqLine  = line;
    enqValid = 1'b1;
    @(negedge clk);
    enqValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; enqValid = 1'b0; enqLine = '0;
    storeValid = 1'b0; storeLine = '0; outReady = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 outValid in reset", 32'(outValid), 0);
    check("R1 dropCount in reset", 32'(dropCount), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 outValid after reset", 32'(outValid), 0);

    // Vector table: one validate, an optional store at a chosen offset
    for (int k = 0; k < NV; k++) begin
      enqLine    = VEC[k][73:42];
      storeLine  = VEC[k][40:9];
      storeValid = VEC[k][41] && (VEC[k][8:1] == 8'd0);
      enqValid   = 1'b1;
      @(negedge clk);
      enqValid = 1'b0;
      for (int e = 1; e <= DELAY; e++) begin
        storeValid = VEC[k][41] && (VEC[k][8:1] == 8'(e));
        #1;
        if (e == DELAY - 1) check($sformatf("R2 early offer vec%0d", k), 32'(outValid), 0);
        if (e == DELAY) begin
          check($sformatf("R4 R6 offer vec%0d", k), 32'(outValid), 32'(VEC[k][0]));
          if (VEC[k][0]) check($sformatf("R2 line vec%0d", k), outLine, VEC[k][73:42]);
        end
        if (e < DELAY) @(negedge clk);
      end
      @(negedge clk);
      storeValid = 1'b0;
      repeat (2) @(negedge clk);
      check($sformatf("R3 drained vec%0d", k), 32'(outValid), 0);
    end

    // R3: order of release, back to back
    push(32'h300); push(32'h340); push(32'h380);
    repeat (DELAY - 3) @(negedge clk);
    check("R3 first", outLine, 32'h300);
    check("R3 first valid", 32'(outValid), 1);
    @(negedge clk);
    check("R3 second", outLine, 32'h340);
    @(negedge clk);
    check("R3 third", outLine, 32'h380);
    @(negedge clk);
    check("R3 empty", 32'(outValid), 0);

    // R5 / R9: one store kills two entries, head discarded silently
    push(32'h700); push(32'h740); push(32'h700);
    repeat (2) @(negedge clk);
    storeValid = 1'b1; storeLine = 32'h700;
    @(negedge clk);
    storeValid = 1'b0;
    repeat (DELAY - 6) @(negedge clk);
    check("R9 cancelled head silent", 32'(outValid), 0);
    @(negedge clk);
    check("R5 survivor offered", 32'(outValid), 1);
    check("R5 survivor line", outLine, 32'h740);
    @(negedge clk);
    check("R5 second match gone", 32'(outValid), 0);
    @(negedge clk);
    check("R5 still quiet", 32'(outValid), 0);
    repeat (3) @(negedge clk);

    // R6: same-edge enqueue and store of one line
    push(32'h900);
    enqValid = 1'b1; enqLine = 32'h900; storeValid = 1'b1; storeLine = 32'h900;
    @(negedge clk);
    enqValid = 1'b0; storeValid = 1'b0;
    repeat (DELAY - 2) @(negedge clk);
    check("R6 older cancelled", 32'(outValid), 0);
    @(negedge clk);
    check("R6 newer survives", 32'(outValid), 1);
    check("R6 newer line", outLine, 32'h900);
    repeat (3) @(negedge clk);

    // R7: stalled offer holds, then cancelled while stalled
    outReady = 1'b0;
    push(32'h500);
    repeat (DELAY - 1) @(negedge clk);
    check("R7 stalled offer", 32'(outValid), 1);
    repeat (4) @(negedge clk);
    check("R7 still offered", 32'(outValid), 1);
    check("R7 line held", outLine, 32'h500);
    storeValid = 1'b1; storeLine = 32'h500;
    #1;
    check("R7 R4 withheld on hit", 32'(outValid), 0);
    @(negedge clk);
    storeValid = 1'b0;
    #1;
    check("R7 cancelled while stalled", 32'(outValid), 0);
    repeat (2) @(negedge clk);

    // R3: stalled then accepted exactly once
    push(32'h540);
    repeat (DELAY + 2) @(negedge clk);
    check("R3 stalled valid", 32'(outValid), 1);
    outReady = 1'b1;
    @(negedge clk);
    check("R3 one per handshake", 32'(outValid), 0);

    // R8: overfill while stalled, then drain
    outReady = 1'b0;
    for (int i = 0; i < DEPTH + 2; i++) push(32'h1000 + 32'(i) * 32'h40);
    check("R8 drop count", 32'(dropCount), 2);
    repeat (DELAY) @(negedge clk);
    outReady = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      check($sformatf("R8 drain valid %0d", i), 32'(outValid), 1);
      check($sformatf("R8 drain line %0d", i), outLine, 32'h1000 + 32'(i) * 32'h40);
      @(negedge clk);
    end
    check("R8 dropped never offered", 32'(outValid), 0);
    check("R8 drop count stable", 32'(dropCount), 2);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule